// File: doc/BRIEF.md
# SWD Raw Bit Sequence Shifter

This block runs an arbitrary train of SWCLK pulses on a serial-wire debug link. During each pulse it either drives bits from a packed vector onto SWDIO or samples SWDIO into a packed capture vector. No protocol framing is added. Request, acknowledge and parity handling belong to other logic. The block is meant for free-form sequences, such as long runs of ones for a line reset or the bit patterns that wake a target from a low-power state.

A single-cycle start pulse launches a sequence. The info word carries two things: the clock count in its low `CNT_W` bits, and a capture flag in the bit just above them. The whole transmit vector is registered when the sequence is accepted. Each bit period is `DLY` cycles with SWCLK low followed by `DLY` cycles with SWCLK high. Captured bits are gathered a byte at a time and then right-aligned, so a short final byte lands in the low bits of its slot. A one-cycle done pulse marks the end of the sequence.

Top module: `swd_seq_shifter`

## Requirements
- R1: The low `CNT_W` bits of `info` set how many SWCLK rising edges a sequence makes. A value of 0 means 2^`CNT_W` edges, which is 64 with the defaults.
- R2: Bit `CNT_W` of `info` (bit 6 by default) equal to 1 selects capture and equal to 0 selects drive. In capture mode `swdio_oe` is low from the accepting edge until the sequence ends. In drive mode it stays high.
- R3: In drive mode, the bit on `swdio_o` during clock k (k counted from 0) is bit k of the `tx_vec` value present at the accepting edge. In byte terms, byte 0 goes first, least significant bit first.
- R4: In capture mode, the bit sampled on clock k lands in `rx_vec[k]`, which is bit k mod 8 of byte k/8. A partial final byte is right-aligned in its byte.
- R5: Every accepted start clears `rx_vec`. When done is asserted, all `rx_vec` bits at or above the clock count are 0.
- R6: Each bit holds SWCLK low for `DLY` cycles and then high for `DLY` cycles. During a sequence, `swdio_o` changes only in the cycle where SWCLK falls. `swdio_i` is sampled in the last low cycle before SWCLK rises.
- R7: `done` is high for exactly one cycle. That cycle immediately follows the high half of the final bit, and SWCLK is high during it.
- R8: A start pulse that arrives while a sequence is running is ignored. Count, mode and transmit data all stay as first accepted.
- R9: After reset and whenever no sequence is running, SWCLK, `swdio_o` and `swdio_oe` are all high and `done` is low. After reset `rx_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sequence |
| info | input | CNT_W+1 | Clock count in the low bits, capture flag in the top bit |
| tx_vec | input | 2^CNT_W | Bits to drive, bit 0 first |
| swdio_i | input | 1 | Sampled SWDIO line |
| swclk | output | 1 | Serial clock, high at rest |
| swdio_o | output | 1 | Driven SWDIO value |
| swdio_oe | output | 1 | SWDIO output enable |
| rx_vec | output | 2^CNT_W | Captured bits, bit 0 first |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bound checker verifies the following on every cycle:
- the output enable is released throughout a capture sequence;
- the data line moves only on falling clock edges;
- done is a single cycle that occurs with the clock high;
- the rising-edge count equals the decoded count;
- capture bits above the count are zero;
- the latched count holds when start is raised while busy;
- the idle line levels are correct.

Only the bench scenarios can show three things. First, that the driven bit order and the captured alignment match the data, including the partial final byte. Second, that the zero-means-maximum count works. Third, that transmit data changed during a run is not picked up.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } seq_phase_e;

endpackage

// File: rtl/swd_seq_ctrl.sv
module swd_seq_ctrl
  import swd_seq_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int DLY   = 2,
  localparam int IDX_W = CNT_W + 1,
  localparam int DLY_W = (DLY > 1) ? $clog2(DLY) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_field,
  input  logic             cap_flag,
  output logic             busy,
  output logic             cap_mode,
  output logic [IDX_W-1:0] bit_idx,
  output logic [IDX_W-1:0] total,
  output logic             accept,
  output logic             enter_low,
  output logic [CNT_W-1:0] next_idx,
  output logic             sample_now,
  output logic             last_bit,
  output logic             finish
);

  localparam logic [IDX_W-1:0] MAX_CNT = IDX_W'(1) << CNT_W;

  seq_phase_e       phase_q, phase_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] total_q, total_d;
  logic             cap_q, cap_d;
  logic             dly_end;

  assign dly_end    = (dly_q == DLY_W'(DLY - 1));
  assign busy       = (phase_q != PH_IDLE);
  assign accept     = (phase_q == PH_IDLE) && start;
  assign last_bit   = (idx_q == (total_q - IDX_W'(1)));
  assign sample_now = (phase_q == PH_LOW) && dly_end;
  assign finish     = (phase_q == PH_HIGH) && dly_end && last_bit;
  assign enter_low  = accept || ((phase_q == PH_HIGH) && dly_end && !last_bit);
  assign next_idx   = accept ? '0 : CNT_W'(idx_q + IDX_W'(1));
  assign cap_mode   = cap_q;
  assign bit_idx    = idx_q;
  assign total      = total_q;

  always_comb begin
    phase_d = phase_q;
    dly_d   = dly_q;
    idx_d   = idx_q;
    total_d = total_q;
    cap_d   = cap_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_LOW;
          dly_d   = '0;
          idx_d   = '0;
          total_d = (cnt_field == '0) ? MAX_CNT : {1'b0, cnt_field};
          cap_d   = cap_flag;
        end
      end
      PH_LOW: begin
        if (dly_end) begin
          phase_d = PH_HIGH;
          dly_d   = '0;
        end else begin
          dly_d = dly_q + DLY_W'(1);
        end
      end
      PH_HIGH: begin
        if (dly_end) begin
          dly_d = '0;
          if (last_bit) begin
            phase_d = PH_IDLE;
          end else begin
            phase_d = PH_LOW;
            idx_d   = idx_q + IDX_W'(1);
          end
        end else begin
          dly_d = dly_q + DLY_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dly_q   <= '0;
      idx_q   <= '0;
      total_q <= '0;
      cap_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      dly_q   <= dly_d;
      idx_q   <= idx_d;
      total_q <= total_d;
      cap_q   <= cap_d;
    end
  end

endmodule

// File: rtl/swd_seq_txsel.sv
module swd_seq_txsel #(
  parameter int CNT_W = 6,
  localparam int VEC_W = 1 << CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VEC_W-1:0] vec_in,
  input  logic [CNT_W-1:0] sel,
  output logic             bit_out
);

  logic [VEC_W-1:0] tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    if (load) tx_d = vec_in;
  end

  assign bit_out = load ? vec_in[sel] : tx_q[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

endmodule

// File: rtl/swd_seq_packer.sv
module swd_seq_packer #(
  parameter int CNT_W = 6,
  localparam int VEC_W  = 1 << CNT_W,
  localparam int NBYTES = (VEC_W + 7) / 8,
  localparam int BI_W   = (CNT_W + 1 > 3) ? CNT_W - 2 : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             din,
  input  logic             last,
  input  logic [BI_W-1:0]  byte_idx,
  output logic [VEC_W-1:0] rx_vec
);

  logic [7:0]       acc_q, acc_d, acc_nx, aligned;
  logic [3:0]       fill_q, fill_d, fill_nx;
  logic [VEC_W-1:0] rx_q, rx_d;
  logic             commit;

  assign acc_nx  = {din, acc_q[7:1]};
  assign fill_nx = fill_q + 4'd1;
  assign commit  = sample && ((fill_nx == 4'd8) || last);
  assign aligned = acc_nx >> (4'd8 - fill_nx);

  always_comb begin
    acc_d  = acc_q;
    fill_d = fill_q;
    rx_d   = rx_q;
    if (clear) begin
      acc_d  = '0;
      fill_d = '0;
      rx_d   = '0;
    end else if (sample) begin
      if (commit) begin
        acc_d  = '0;
        fill_d = '0;
      end else begin
        acc_d  = acc_nx;
        fill_d = fill_nx;
      end
      for (int b = 0; b < NBYTES; b++) begin
        if (commit && (byte_idx == BI_W'(b))) rx_d[b*8 +: 8] = aligned;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      rx_q   <= '0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      rx_q   <= rx_d;
    end
  end

  assign rx_vec = rx_q;

endmodule

// File: rtl/swd_seq_shifter.sv
module swd_seq_shifter #(
  parameter int CNT_W = 6,
  parameter int DLY   = 2,
  localparam int INFO_W = CNT_W + 1,
  localparam int VEC_W  = 1 << CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INFO_W-1:0] info,
  input  logic [VEC_W-1:0]  tx_vec,
  input  logic              swdio_i,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  output logic [VEC_W-1:0]  rx_vec,
  output logic              done
);

  localparam int IDX_W = CNT_W + 1;
  localparam int BI_W  = CNT_W - 2;

  logic             busy, cap_mode, accept, enter_low, sample_now, last_bit, finish;
  logic [IDX_W-1:0] bit_idx, total;
  logic [CNT_W-1:0] next_idx;
  logic             tx_bit, cap_sel;

  logic swclk_q, swclk_d;
  logic dout_q, dout_d;
  logic oe_q, oe_d;
  logic done_q, done_d;

  swd_seq_ctrl #(.CNT_W(CNT_W), .DLY(DLY)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cnt_field  (info[CNT_W-1:0]),
    .cap_flag   (info[CNT_W]),
    .busy       (busy),
    .cap_mode   (cap_mode),
    .bit_idx    (bit_idx),
    .total      (total),
    .accept     (accept),
    .enter_low  (enter_low),
    .next_idx   (next_idx),
    .sample_now (sample_now),
    .last_bit   (last_bit),
    .finish     (finish)
  );

  swd_seq_txsel #(.CNT_W(CNT_W)) u_txsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .vec_in  (tx_vec),
    .sel     (next_idx),
    .bit_out (tx_bit)
  );

  swd_seq_packer #(.CNT_W(CNT_W)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .sample   (sample_now && cap_mode),
    .din      (swdio_i),
    .last     (last_bit),
    .byte_idx (bit_idx[IDX_W-1:3]),
    .rx_vec   (rx_vec)
  );

  assign cap_sel = accept ? info[CNT_W] : cap_mode;

  always_comb begin
    swclk_d = swclk_q;
    dout_d  = dout_q;
    oe_d    = oe_q;
    done_d  = finish;
    if (enter_low) begin
      swclk_d = 1'b0;
      dout_d  = cap_sel ? 1'b1 : tx_bit;
    end else if (sample_now) begin
      swclk_d = 1'b1;
    end
    if (accept) oe_d = !info[CNT_W];
    if (finish) begin
      oe_d   = 1'b1;
      dout_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swclk_q <= 1'b1;
      dout_q  <= 1'b1;
      oe_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      swclk_q <= swclk_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  assign swclk    = swclk_q;
  assign swdio_o  = dout_q;
  assign swdio_oe = oe_q;
  assign done     = done_q;

endmodule

// File: rtl/swd_seq_shifter_chk.sv
module swd_seq_shifter_chk #(
  parameter int CNT_W = 6,
  localparam int IDX_W = CNT_W + 1,
  localparam int VEC_W = 1 << CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             cap_mode,
  input logic [IDX_W-1:0] total,
  input logic             swclk,
  input logic             swdio_o,
  input logic             swdio_oe,
  input logic [VEC_W-1:0] rx_vec,
  input logic             done
);

  logic [IDX_W:0] rise_cnt;
  logic           clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      clk_prev <= 1'b1;
    end else begin
      clk_prev <= swclk;
      if (!busy)                  rise_cnt <= '0;
      else if (swclk && !clk_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R1
  rise_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rise_cnt == {1'b0, total}));

  // R2
  cap_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cap_mode) |-> !swdio_oe);

  // R5
  rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rx_vec >> total) == '0));

  // R6
  dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(swdio_o)) |-> $fell(swclk));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (swclk && !busy));

  // R8
  busy_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(total));

  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swclk && swdio_o && swdio_oe));

endmodule

bind swd_seq_shifter swd_seq_shifter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .cap_mode (cap_mode),
  .total    (total),
  .swclk    (swclk),
  .swdio_o  (swdio_o),
  .swdio_oe (swdio_oe),
  .rx_vec   (rx_vec),
  .done     (done)
);

// File: tb/swd_seq_shifter_test.sv
module swd_seq_shifter_test;

  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [6:0]  info;
  logic [63:0] txv;
  logic        swdio_i;
  logic        swclk, swdio_o, swdio_oe, done;
  logic [63:0] rx_vec;

  int nchk = 0;
  int nfail = 0;

  logic [63:0] pat = '0;
  logic [63:0] drv = '0;
  logic [6:0]  rcnt = '0;
  int          lowcyc = 0;
  int          oe0 = 0;
  bit          mon_on = 1'b0;

  always #2 clk = ~clk;

  swd_seq_shifter #(.CNT_W(6), .DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .info(info), .tx_vec(txv),
    .swdio_i(swdio_i), .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
    .rx_vec(rx_vec), .done(done)
  );

  assign swdio_i = pat[rcnt[5:0]];

  always @(posedge swclk) begin
    if (mon_on) begin
      if (rcnt < 7'd64) drv[rcnt[5:0]] = swdio_o;
      rcnt = rcnt + 7'd1;
    end
  end

  always @(negedge clk) begin
    if (mon_on && !swclk) begin
      lowcyc = lowcyc + 1;
      if (!swdio_oe) oe0 = oe0 + 1;
    end
  end

  function automatic int count_of(input logic [6:0] inf);
    return (inf[5:0] == 6'd0) ? 64 : int'(inf[5:0]);
  endfunction

  function automatic logic [63:0] mask_of(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [6:0] inf, input logic [63:0] tx, input logic [63:0] p, input bit poke);
    int n;
    int cyc;
    logic [63:0] m;
    n = count_of(inf);
    m = mask_of(n);
    @(negedge clk);
    pat = p; rcnt = '0; drv = '0; lowcyc = 0; oe0 = 0; mon_on = 1'b1;
    info = inf; txv = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      // R8: a second request with another count, mode and data must be ignored
      info = {~inf[6], 6'd5}; txv = ~tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R7 done seen", 64'(done), 64'd1);
    chk(rcnt == 7'(n), "R1/R8 rising edge count", 64'(rcnt), 64'(n));
    chk(lowcyc == DLY * n, "R6 low cycles", 64'(lowcyc), 64'(DLY * n));
    chk(swclk, "R7 clock high at done", 64'(swclk), 64'd1);
    if (inf[6]) begin
      chk(oe0 == lowcyc, "R2 oe low in capture", 64'(oe0), 64'(lowcyc));
      chk(rx_vec == (p & m), "R4 capture alignment", rx_vec, p & m);
    end else begin
      chk(oe0 == 0, "R2 oe high in drive", 64'(oe0), 64'd0);
      chk((drv & m) == (tx & m), "R3 drive order", drv & m, tx & m);
      chk(rx_vec == '0, "R5 capture cleared in drive", rx_vec, 64'd0);
    end
    chk((rx_vec & ~m) == '0, "R5 upper bits zero", rx_vec & ~m, 64'd0);
    mon_on = 1'b0;
    @(negedge clk);
    chk(!done, "R7 done single cycle", 64'(done), 64'd0);
    chk(swclk && swdio_o && swdio_oe, "R9 idle levels", {61'd0, swclk, swdio_o, swdio_oe}, 64'd7);
  endtask

  initial begin
    #(4 * 190000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0; start = 1'b0; info = '0; txv = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(swclk && swdio_o && swdio_oe && !done, "R9 reset levels",
        {60'd0, swclk, swdio_o, swdio_oe, done}, 64'he);
    chk(rx_vec == '0, "R9 reset capture", rx_vec, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 zero means 64, R4 full vector
    run(7'h40, 64'd0, 64'hA5C3_0F81_7E24_DB96, 1'b0);
    // R4 single bit lands in bit 0
    run(7'h41, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    // R4 partial final byte right-aligned
    run(7'h4D, 64'd0, 64'h0000_0000_0000_1B6D, 1'b0);
    run(7'h43, 64'd0, 64'h0000_0000_0000_0005, 1'b0);
    // R3 drive, one byte and full 64
    run(7'h08, 64'h0000_0000_0000_00B4, 64'd0, 1'b0);
    run(7'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);
    run(7'h3F, 64'h1234_5678_9ABC_DEF0, 64'd0, 1'b0);
    // R8 start while busy, in both modes
    run(7'h10, 64'h0000_0000_0000_C3A5, 64'd0, 1'b1);
    run(7'h50, 64'd0, 64'h0000_0000_0000_96E1, 1'b1);

    for (int i = 0; i < 24; i++) begin
      logic [6:0]  ri;
      logic [63:0] rt, rp;
      ri = 7'($urandom);
      rt = {$urandom, $urandom};
      rp = {$urandom, $urandom};
      run(ri, rt, rp, ($urandom % 4) == 0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule